// File: doc/BRIEF.md
# SMBus Byte Register Slave

This block is the protocol engine of a two-wire slave that owns four byte-wide registers. It works on clean SCL and SDA samples that have already been filtered and synchronised to the system clock. It answers four kinds of transfer. Write Byte and Read Byte go to its own address. A broadcast write goes to a shared address and can be masked. An alert-response read returns the device's own address while an alert is pending.

A write is held until the STOP condition and is only then handed to the register file as a one-cycle strobe. A repeated START or an unexpected extra byte throws it away. Reads take their data from the register file through an index output, which keeps the last command byte's register number. The block pulls SDA low only when it acknowledges a byte or sends a zero bit. When its enable input is low it ignores the bus.

Top module: `smbus_byte_slave`

## Requirements
- R1: The own 7-bit address is {1, 0, dev_addr[4:0]}. A match in either direction is acknowledged by pulling SDA low during the ninth clock. Each match gives one `addressed_stb` pulse, and at most one of `wr_stb`, `addressed_stb`, `ara_stb` is high in any cycle.
- R2: A write to address 1011110 is acknowledged and handled like an own-address write only while `mass_wr_en` is 1. With `mass_wr_en` at 0 it is not acknowledged.
- R3: A read from address 0001100 is acknowledged only while `alert_pending` is 1. The acknowledge gives one `ara_stb` pulse, and the byte returned is {own 7-bit address, 0}, sent MSB first.
- R4: An address that matches nothing is not acknowledged, and SDA stays released for every following byte until the next START.
- R5: In a write, the command byte's two low bits choose the register and its upper six bits are ignored. Command and data bytes are acknowledged. The data appears on `wr_data` with the index on `wr_idx` as a one-cycle `wr_stb`, one clock after the STOP is sampled, and never at any other time.
- R6: A repeated START that comes after the data byte and before STOP drops the write: no `wr_stb` follows and the register keeps its old value.
- R7: After an own-address read, the block sends the byte on `rd_data` (for register `rd_idx`, the last command index) MSB first. A master ACK makes it send the register again. A master NACK ends the transfer.
- R8: `sda_pull` changes only in the clock after SCL was sampled low.
- R9: While `enable` is 0 no byte is acknowledged and all strobes and `sda_pull` stay 0. The register index returns to 0.
- R10: A byte after the data byte in a write is not acknowledged and cancels the pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Bus interface enable; low ignores traffic and clears the index |
| scl_i | input | 1 | Filtered, synchronised SCL sample |
| sda_i | input | 1 | Filtered, synchronised SDA sample (wired-AND bus level) |
| dev_addr | input | 5 | Configured low five bits of the own address |
| mass_wr_en | input | 1 | Allows the broadcast write address |
| alert_pending | input | 1 | An alert is pending, so the alert response address is answered |
| rd_data | input | 8 | Contents of register `rd_idx` |
| rd_idx | output | 2 | Register index selected by the last command byte |
| sda_pull | output | 1 | Drive SDA low when 1 |
| wr_stb | output | 1 | One-cycle write commit strobe |
| wr_idx | output | 2 | Register index of the committed write |
| wr_data | output | 8 | Data of the committed write |
| addressed_stb | output | 1 | One-cycle pulse when the own address is acknowledged |
| ara_stb | output | 1 | One-cycle pulse when the alert response read is acknowledged |

## Verification
Each bus event takes effect one clock after the sample that shows it. An acknowledge or data bit is driven in the clock after SCL is seen low, and a committed write strobe appears in the clock after SDA is seen rising with SCL high. The bench keeps every SCL phase four clocks long and reads SDA three clocks after the SCL rise, long after any driven level has settled. Strobes are compared against the model's queues and counters at each falling clock edge, so any strobe that comes early, late or without cause is flagged in the cycle it appears.

// File: rtl/smbr_pkg.sv
package smbr_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CFG_W  = ADDR_W - 2;

  localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'b1011110;
  localparam logic [ADDR_W-1:0] ARA_ADDR   = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_HOLD, ST_SKIP
  } st_e;

  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} kind_e;
  typedef enum logic [1:0] {N_CMD, N_DATA, N_HOLD, N_TX} next_e;

  function automatic logic [ADDR_W-1:0] own_addr(input logic [CFG_W-1:0] cfg);
    return {2'b10, cfg};
  endfunction

  function automatic logic [BYTE_W-1:0] ara_reply(input logic [CFG_W-1:0] cfg);
    return {own_addr(cfg), 1'b0};
  endfunction
endpackage

// File: rtl/smbr_line_events.sv
module smbr_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev_start = scl_q & scl_i & sda_q & ~sda_i;
    ev_stop  = scl_q & scl_i & ~sda_q & sda_i;
    ev_rise  = ~scl_q & scl_i;
    ev_fall  = scl_q & ~scl_i;
  end
endmodule

// File: rtl/smbr_addr_decode.sv
module smbr_addr_decode
  import smbr_pkg::*;
(
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic [CFG_W-1:0]  dev_addr,
  input  logic              mass_wr_en,
  input  logic              alert_pending,
  output logic              rd_dir,
  output logic              hit_own,
  output logic              hit_bcast,
  output logic              hit_ara,
  output logic              addr_ack
);
  logic [ADDR_W-1:0] a7;

  always_comb begin
    a7        = addr_byte[BYTE_W-1:1];
    rd_dir    = addr_byte[0];
    hit_own   = (a7 == own_addr(dev_addr));
    hit_bcast = (a7 == BCAST_ADDR) & mass_wr_en & ~rd_dir;
    hit_ara   = (a7 == ARA_ADDR) & alert_pending & rd_dir;
    addr_ack  = hit_own | hit_bcast | hit_ara;
  end
endmodule

// File: rtl/smbus_byte_slave.sv
module smbus_byte_slave
  import smbr_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [4:0]        dev_addr,
  input  logic              mass_wr_en,
  input  logic              alert_pending,
  input  logic [7:0]        rd_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [7:0]        wr_data,
  output logic              addressed_stb,
  output logic              ara_stb
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX   = CNT_W'(BYTE_W - 1);

  logic ev_start, ev_stop, ev_rise, ev_fall;
  logic rd_dir, hit_own, hit_bcast, hit_ara, addr_ack;

  st_e                st;
  kind_e              kind;
  next_e              after;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  rx_sh, tx_sh, pend_data, tx_byte;
  logic [IDX_W-1:0]   idx;
  logic               wr_pending, ara_mode, mst_ack, pull_q;

  smbr_line_events u_ev (
    .clk, .rst_n, .scl_i, .sda_i,
    .ev_start, .ev_stop, .ev_rise, .ev_fall
  );

  smbr_addr_decode u_dec (
    .addr_byte(rx_sh), .dev_addr, .mass_wr_en, .alert_pending,
    .rd_dir, .hit_own, .hit_bcast, .hit_ara, .addr_ack
  );

  assign tx_byte  = ara_mode ? ara_reply(dev_addr) : rd_data;
  assign sda_pull = pull_q;
  assign rd_idx   = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      kind          <= K_ADDR;
      after         <= N_CMD;
      cnt           <= '0;
      rx_sh         <= '0;
      tx_sh         <= '0;
      pend_data     <= '0;
      idx           <= '0;
      wr_pending    <= 1'b0;
      ara_mode      <= 1'b0;
      mst_ack       <= 1'b0;
      pull_q        <= 1'b0;
      wr_stb        <= 1'b0;
      wr_idx        <= '0;
      wr_data       <= '0;
      addressed_stb <= 1'b0;
      ara_stb       <= 1'b0;
    end else begin
      wr_stb        <= 1'b0;
      addressed_stb <= 1'b0;
      ara_stb       <= 1'b0;
      if (!enable) begin
        st         <= ST_IDLE;
        pull_q     <= 1'b0;
        wr_pending <= 1'b0;
        idx        <= '0;
        cnt        <= '0;
      end else if (ev_stop) begin
        if (wr_pending) begin
          wr_stb  <= 1'b1;
          wr_idx  <= idx;
          wr_data <= pend_data;
        end
        wr_pending <= 1'b0;
        pull_q     <= 1'b0;
        st         <= ST_IDLE;
      end else if (ev_start) begin
        wr_pending <= 1'b0;
        pull_q     <= 1'b0;
        cnt        <= '0;
        kind       <= K_ADDR;
        st         <= ST_RX;
      end else begin
        case (st)
          ST_RX: begin
            if (ev_rise) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_i};
              cnt   <= cnt + 1'b1;
            end else if (ev_fall && cnt == BYTE_DONE) begin
              case (kind)
                K_ADDR: begin
                  if (addr_ack) begin
                    pull_q        <= 1'b1;
                    st            <= ST_ACK;
                    after         <= rd_dir ? N_TX : N_CMD;
                    ara_mode      <= hit_ara & ~hit_own;
                    addressed_stb <= hit_own;
                    ara_stb       <= hit_ara & ~hit_own;
                  end else begin
                    st <= ST_SKIP;
                  end
                end
                K_CMD: begin
                  pull_q <= 1'b1;
                  st     <= ST_ACK;
                  idx    <= rx_sh[IDX_W-1:0];
                  after  <= N_DATA;
                end
                default: begin
                  pull_q     <= 1'b1;
                  st         <= ST_ACK;
                  pend_data  <= rx_sh;
                  wr_pending <= 1'b1;
                  after      <= N_HOLD;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (ev_fall) begin
              cnt <= '0;
              case (after)
                N_CMD:  begin kind <= K_CMD;  st <= ST_RX; pull_q <= 1'b0; end
                N_DATA: begin kind <= K_DATA; st <= ST_RX; pull_q <= 1'b0; end
                N_HOLD: begin st <= ST_HOLD; pull_q <= 1'b0; end
                default: begin
                  tx_sh  <= tx_byte;
                  pull_q <= ~tx_byte[BYTE_W-1];
                  st     <= ST_TX;
                end
              endcase
            end
          end
          ST_TX: begin
            if (ev_fall) begin
              if (cnt == LAST_TX) begin
                pull_q <= 1'b0;
                st     <= ST_MACK;
              end else begin
                tx_sh  <= tx_sh << 1;
                pull_q <= ~tx_sh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (ev_rise) begin
              mst_ack <= ~sda_i;
            end else if (ev_fall) begin
              if (mst_ack) begin
                cnt    <= '0;
                tx_sh  <= tx_byte;
                pull_q <= ~tx_byte[BYTE_W-1];
                st     <= ST_TX;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_HOLD: begin
            if (ev_rise) begin
              cnt <= 1;
            end else if (ev_fall && cnt != '0) begin
              wr_pending <= 1'b0;
              st         <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbus_byte_slave_chk.sv
module smbus_byte_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_i,
  input logic sda_pull,
  input logic wr_stb,
  input logic addressed_stb,
  input logic ara_stb,
  input logic alert_pending,
  input logic ev_start,
  input logic ev_stop,
  input logic wr_pending
);
  assert_sda_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && $past(enable)) |-> !$past(scl_i));

  assert_commit_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(ev_stop));

  assert_restart_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && enable) |=> !wr_pending);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sda_pull && !wr_stb && !addressed_stb && !ara_stb));

  assert_ara_needs_alert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ara_stb |-> $past(alert_pending));

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, addressed_stb, ara_stb}));
endmodule

bind smbus_byte_slave smbus_byte_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_i(scl_i),
  .sda_pull(sda_pull), .wr_stb(wr_stb), .addressed_stb(addressed_stb),
  .ara_stb(ara_stb), .alert_pending(alert_pending), .ev_start(ev_start),
  .ev_stop(ev_stop), .wr_pending(wr_pending)
);

// File: tb/test_smbus_byte_slave.sv
`timescale 1ns/1ps
module test_smbus_byte_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [4:0] dev_addr = 5'b01011;
  logic mass_wr_en = 1'b1;
  logic alert_pending = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] rd_idx, wr_idx;
  logic sda_pull, wr_stb, addressed_stb, ara_stb;
  logic [7:0] wr_data;
  wire sda_bus = sda_m & ~sda_pull;

  // stand-in register file (its contents are outside the block)
  logic [7:0] regs [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
  assign rd_data = regs[rd_idx];

  int checks = 0, errors = 0;
  int addr_cnt = 0, ara_cnt = 0, r8_viol = 0;
  logic [9:0] expq [$];
  logic prev_pull = 1'b0, prev_scl = 1'b1;

  localparam logic [6:0] OWN = 7'b1001011;

  always #2.5 clk = ~clk;

  smbus_byte_slave i_smbus_byte_slave (
    .clk, .rst_n, .enable, .scl_i(scl_m), .sda_i(sda_bus), .dev_addr,
    .mass_wr_en, .alert_pending, .rd_data, .rd_idx, .sda_pull, .wr_stb,
    .wr_idx, .wr_data, .addressed_stb, .ara_stb
  );

  always @(posedge clk) if (wr_stb) regs[wr_idx] <= wr_data;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model comparison of strobes and SDA timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (expq.size() == 0) chk(0, "R5/R6 unexpected write", {wr_idx, wr_data}, 0);
        else begin
          logic [9:0] e;
          e = expq.pop_front();
          chk({wr_idx, wr_data} == e, "R5 write commit", {wr_idx, wr_data}, e);
        end
      end
      if (addressed_stb) addr_cnt++;
      if (ara_stb) ara_cnt++;
      if (sda_pull != prev_pull && prev_scl && scl_m) r8_viol++;
    end
    prev_pull = sda_pull;
    prev_scl  = scl_m;
  end

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic b);
    scl_m = 1'b0; w(2); sda_m = b; w(2); scl_m = 1'b1; w(4);
  endtask

  task automatic bit_in(output logic b);
    scl_m = 1'b0; w(2); sda_m = 1'b1; w(2); scl_m = 1'b1; w(3); b = sda_bus; w(1);
  endtask

  task automatic do_start();
    scl_m = 1'b0; w(2); sda_m = 1'b1; w(2); scl_m = 1'b1; w(3); sda_m = 1'b0; w(3);
  endtask

  task automatic do_stop();
    scl_m = 1'b0; w(2); sda_m = 1'b0; w(2); scl_m = 1'b1; w(3); sda_m = 1'b1; w(3);
  endtask

  task automatic send(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic recv(output logic [7:0] b, input bit give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(!give_ack);
  endtask

  bit ak;
  logic [7:0] rb;

  initial begin
    w(4);
    rst_n = 1'b1;
    w(2);
    chk(sda_pull == 0, "R8 reset releases SDA", sda_pull, 0);
    chk(wr_stb == 0 && addressed_stb == 0, "R5 reset strobes low", wr_stb, 0);

    // own write, command with upper bits set -> register 1
    do_start();
    send({OWN, 1'b0}, ak); chk(ak, "R1 own address ack", ak, 1);
    send(8'hFD, ak);       chk(ak, "R5 command ack", ak, 1);
    expq.push_back({2'd1, 8'h3C});
    send(8'h3C, ak);       chk(ak, "R5 data ack", ak, 1);
    do_stop(); w(4);
    chk(regs[1] == 8'h3C, "R5 register 1 written", regs[1], 8'h3C);

    do_start();
    send({OWN, 1'b0}, ak); send(8'h00, ak);
    expq.push_back({2'd0, 8'hA5});
    send(8'hA5, ak); do_stop(); w(4);

    // Read Byte of register 1, master acks once then nacks
    do_start();
    send({OWN, 1'b0}, ak); send(8'h01, ak);
    do_start();
    send({OWN, 1'b1}, ak); chk(ak, "R7 read address ack", ak, 1);
    recv(rb, 1'b1);        chk(rb == 8'h3C, "R7 read byte", rb, 8'h3C);
    recv(rb, 1'b0);        chk(rb == 8'h3C, "R7 repeat after master ack", rb, 8'h3C);
    do_stop(); w(4);

    // write interrupted by repeated start is dropped, register 2 unchanged
    do_start();
    send({OWN, 1'b0}, ak); send(8'h02, ak); send(8'h77, ak);
    chk(ak, "R6 data acked before restart", ak, 1);
    do_start();
    send({OWN, 1'b1}, ak);
    recv(rb, 1'b0);        chk(rb == 8'h33, "R6 register 2 kept", rb, 8'h33);
    do_stop(); w(4);

    // broadcast write enabled
    do_start();
    send(8'b1011_1100, ak); chk(ak, "R2 broadcast ack", ak, 1);
    send(8'h03, ak);
    expq.push_back({2'd3, 8'h5A});
    send(8'h5A, ak); do_stop(); w(4);
    // broadcast masked
    mass_wr_en = 1'b0;
    do_start();
    send(8'b1011_1100, ak); chk(!ak, "R2 masked broadcast nack", ak, 0);
    send(8'h00, ak); do_stop(); w(4);
    mass_wr_en = 1'b1;

    // foreign address
    do_start();
    send({7'b1001010, 1'b0}, ak); chk(!ak, "R4 foreign address nack", ak, 0);
    send(8'h00, ak);              chk(!ak, "R4 SDA stays released", ak, 0);
    do_stop(); w(4);

    // alert response read
    alert_pending = 1'b1;
    do_start();
    send(8'b0001_1001, ak); chk(ak, "R3 alert response ack", ak, 1);
    recv(rb, 1'b0);         chk(rb == {OWN, 1'b0}, "R3 returned address", rb, {OWN, 1'b0});
    do_stop(); w(4);
    alert_pending = 1'b0;
    do_start();
    send(8'b0001_1001, ak); chk(!ak, "R3 no alert -> nack", ak, 0);
    do_stop(); w(4);
    chk(ara_cnt == 1, "R3 ara_stb count", ara_cnt, 1);

    // extra byte cancels the write
    do_start();
    send({OWN, 1'b0}, ak); send(8'h03, ak); send(8'hEE, ak);
    send(8'h01, ak); chk(!ak, "R10 extra byte nack", ak, 0);
    do_stop(); w(4);
    chk(regs[3] == 8'h5A, "R10 register 3 kept", regs[3], 8'h5A);

    // disabled interface
    enable = 1'b0; w(3);
    do_start();
    send({OWN, 1'b0}, ak); chk(!ak, "R9 disabled nack", ak, 0);
    do_stop(); w(2);
    enable = 1'b1; w(2);
    chk(rd_idx == 0, "R9 index cleared", rd_idx, 0);
    do_start();
    send({OWN, 1'b1}, ak);
    recv(rb, 1'b0); chk(rb == 8'hA5, "R9 read from register 0", rb, 8'hA5);
    do_stop(); w(6);

    chk(addr_cnt == 8, "R1 addressed_stb count", addr_cnt, 8);
    chk(expq.size() == 0, "R5 all writes committed", expq.size(), 0);
    chk(r8_viol == 0, "R8 SDA changed with SCL high", r8_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule